// File: doc/BRIEF.md
# Adaptive Mid-Bit Sampling Timer

This block produces the per-bit sample strobe for a low-speed (1.5 Mb/s) or full-speed (12 Mb/s) serial bus receiver. It holds the bit period and the position of the next sample point as unsigned fixed-point numbers with 16 fractional bits. A start pulse reloads the nominal period for the selected speed and aims the first sample half a period after the packet's opening edge. Each later sample point lies one period after the previous one, and an edge-check strobe fires half a period before it.

At every sample strobe, the symbol decoder reports the current line symbol and whether it differs from the symbol sampled one bit earlier. The timer compares that information with the line state it captured at the edge-check strobe. If the transition had already arrived at the edge check, the local clock is running slow: the period shrinks a little and the next sample point moves earlier. If the transition had not yet arrived, the clock is running fast: the period grows and the sample point moves later. The period always stays within a fixed band around nominal, which covers the rate tolerance allowed at each speed. An idle input stops the strobes until the next start pulse.

Top module: `adaptive_bit_timer`

## Requirements
- R1: While reset is high, and after it falls until the first accepted start pulse, both sample_stb and edge_stb stay low.
- R2: The nominal period in 16-bit-fraction fixed point is floor(CLK_HZ*65536/rate), with rate 1.5e6 when speed_ls is 1 at the start pulse and 12e6 when it is 0. At CLK_HZ = 48 MHz these periods are 32.0 and 4.0 clocks.
- R3: A start accepted at a clock edge sets the cycle count to 0 in the following cycle, with the count rising by one per cycle after that. The first sample position P is NOM/2 + 0.5. sample_stb is high in the cycle whose count equals floor(P), and edge_stb is high in the cycle whose count equals floor(P - period/2). The two strobes are never high together.
- R4: When no adjustment applies, each sample strobe advances P by the current period and leaves the period unchanged.
- R5: Symbol codes are 00 SE0, 01 J, 10 K, 11 SE1. At a sample strobe with sym_changed high, the edge-check symbol J or K, and line_sym equal to it, P advances by per - (per>>7) - (per>>9) and the period becomes per - (per>>10).
- R6: At a sample strobe with sym_changed high, line_sym J or K, and an edge-check symbol that is J or K but differs from line_sym, P advances by per + (per>>7) + (per>>9) and the period becomes per + (per>>10).
- R7: No adjustment (R4 behaviour) occurs when sym_changed is low, when the edge-check symbol is SE0 or SE1, or when line_sym at the sample is SE0 or SE1.
- R8: The adjusted period is clamped to the range [NOM - floor(NOM/50), NOM + floor(NOM/50)] for the speed loaded at the last start.
- R9: A start pulse while the timer runs restarts it as in R3 and reloads the nominal period for the speed selected at that pulse.
- R10: Both strobes are low in any cycle where idle is high. The timer stops at that edge and stays stopped until a later start. A start pulse in a cycle where idle is high is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse at the start-of-packet edge |
| speed_ls | input | 1 | 1 selects low speed, 0 selects full speed; sampled with start |
| idle | input | 1 | Stops the strobes until the next start |
| line_sym | input | 2 | Current line symbol: 00 SE0, 01 J, 10 K, 11 SE1 |
| sym_changed | input | 1 | Sampled symbol differs from the previous one; read at sample_stb |
| sample_stb | output | 1 | Mid-bit sample strobe |
| edge_stb | output | 1 | Edge-check strobe, half a period before each sample |

## Verification
The bench builds the block with CLK_HZ = 48 MHz, INT_W = 16 and FRAC_W = 16. This gives an exact 4-clock full-speed period and a 32-clock low-speed period, so every nominal strobe cycle is a small whole number that can be checked by hand. With periods that short, a run of 70 one-sided corrections pushes the period well past the ±2% band within a few hundred clocks. The clamp then shows up as a shift of whole cycles in later strobes. The phase steps of about 1% move the integer sample cycle within a few bits, so each correction direction is visible at the ports.

// File: rtl/abt_pkg.sv
package abt_pkg;

    typedef enum logic [1:0] {
        SYM_SE0 = 2'b00,
        SYM_J   = 2'b01,
        SYM_K   = 2'b10,
        SYM_SE1 = 2'b11
    } lsym_e;

    typedef enum logic [1:0] {
        ADJ_HOLD    = 2'd0,
        ADJ_SHORTEN = 2'd1,
        ADJ_STRETCH = 2'd2
    } adj_e;

    localparam longint FS_RATE = 64'd12_000_000;
    localparam longint LS_RATE = 64'd1_500_000;

    // period trim shift (~0.1%) and phase slip shifts (~1%)
    localparam int TRIM_SH  = 10;
    localparam int SLIP_SHA = 7;
    localparam int SLIP_SHB = 9;

    function automatic longint nominal_q(input longint clk_hz, input longint rate,
                                         input int frac_w);
        return (clk_hz <<< frac_w) / rate;
    endfunction

    function automatic logic is_data(input lsym_e s);
        return (s == SYM_J) || (s == SYM_K);
    endfunction

endpackage

// File: rtl/abt_period.sv
module abt_period
    import abt_pkg::*;
#(
    parameter int             PW     = 32,
    parameter logic [PW-1:0]  NOM_FS = '0,
    parameter logic [PW-1:0]  NOM_LS = '0,
    parameter logic [PW-1:0]  FS_LO  = '0,
    parameter logic [PW-1:0]  FS_HI  = '0,
    parameter logic [PW-1:0]  LS_LO  = '0,
    parameter logic [PW-1:0]  LS_HI  = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          speed_ls,
    input  logic          apply,
    input  adj_e          adj,
    output logic [PW-1:0] per,
    output logic [PW-1:0] per_lo,
    output logic [PW-1:0] per_hi
);

    logic          ls_q;
    logic [PW-1:0] trim;
    logic [PW-1:0] raw;
    logic [PW-1:0] bounded;

    always_comb begin
        per_lo = ls_q ? LS_LO : FS_LO;
        per_hi = ls_q ? LS_HI : FS_HI;
        trim   = per >> TRIM_SH;
        unique case (adj)
            ADJ_SHORTEN: raw = per - trim;
            ADJ_STRETCH: raw = per + trim;
            default:     raw = per;
        endcase
        if (raw < per_lo)      bounded = per_lo;
        else if (raw > per_hi) bounded = per_hi;
        else                   bounded = raw;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            per  <= NOM_FS;
            ls_q <= 1'b0;
        end else if (load) begin
            per  <= speed_ls ? NOM_LS : NOM_FS;
            ls_q <= speed_ls;
        end else if (apply) begin
            per  <= bounded;
        end
    end

endmodule

// File: rtl/abt_phase.sv
module abt_phase
    import abt_pkg::*;
#(
    parameter int            INT_W  = 16,
    parameter int            FRAC_W = 16,
    parameter int            PW     = INT_W + FRAC_W,
    parameter logic [PW-1:0] NOM_FS = '0,
    parameter logic [PW-1:0] NOM_LS = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          speed_ls,
    input  logic          halt,
    input  logic [PW-1:0] per,
    input  adj_e          adj,
    output logic          sample_hit,
    output logic          edge_hit
);

    localparam logic [PW-1:0] HALF_ONE = PW'(1) << (FRAC_W - 1);

    logic [INT_W-1:0] cnt;
    logic [PW-1:0]    tgt;
    logic             run;
    logic [PW-1:0]    edge_pos;
    logic [PW-1:0]    slip;
    logic [PW-1:0]    tgt_next;
    logic [PW-1:0]    cnt_ext;

    always_comb begin
        cnt_ext    = PW'(cnt);
        edge_pos   = tgt - (per >> 1);
        sample_hit = run && !halt && ((tgt >> FRAC_W) == cnt_ext);
        edge_hit   = run && !halt && ((edge_pos >> FRAC_W) == cnt_ext);
        slip       = (per >> SLIP_SHA) + (per >> SLIP_SHB);
        unique case (adj)
            ADJ_SHORTEN: tgt_next = tgt + per - slip;
            ADJ_STRETCH: tgt_next = tgt + per + slip;
            default:     tgt_next = tgt + per;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run <= 1'b0;
            cnt <= '0;
            tgt <= '0;
        end else if (load) begin
            run <= 1'b1;
            cnt <= '0;
            tgt <= ((speed_ls ? NOM_LS : NOM_FS) >> 1) + HALF_ONE;
        end else begin
            if (run)        cnt <= cnt + 1'b1;
            if (sample_hit) tgt <= tgt_next;
            if (halt)       run <= 1'b0;
        end
    end

endmodule

// File: rtl/abt_judge.sv
module abt_judge
    import abt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       edge_hit,
    input  logic [1:0] line_sym,
    input  logic       sym_changed,
    output adj_e       adj
);

    lsym_e edge_q;
    lsym_e now_sym;

    always_comb begin
        now_sym = lsym_e'(line_sym);
        if (!sym_changed || !is_data(edge_q) || !is_data(now_sym))
            adj = ADJ_HOLD;
        else if (edge_q == now_sym)
            adj = ADJ_SHORTEN;
        else
            adj = ADJ_STRETCH;
    end

    always_ff @(posedge clk) begin
        if (rst)           edge_q <= SYM_SE0;
        else if (edge_hit) edge_q <= now_sym;
    end

endmodule

// File: rtl/adaptive_bit_timer.sv
module adaptive_bit_timer
    import abt_pkg::*;
#(
    parameter longint CLK_HZ  = 64'd48_000_000,
    parameter int     INT_W   = 16,
    parameter int     FRAC_W  = 16,
    parameter int     TOL_DIV = 50
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       speed_ls,
    input  logic       idle,
    input  logic [1:0] line_sym,
    input  logic       sym_changed,
    output logic       sample_stb,
    output logic       edge_stb
);

    localparam int     PW    = INT_W + FRAC_W;
    localparam longint FS_NQ = nominal_q(CLK_HZ, FS_RATE, FRAC_W);
    localparam longint LS_NQ = nominal_q(CLK_HZ, LS_RATE, FRAC_W);
    localparam logic [PW-1:0] NOM_FS = PW'(FS_NQ);
    localparam logic [PW-1:0] NOM_LS = PW'(LS_NQ);
    localparam logic [PW-1:0] FS_LO  = PW'(FS_NQ - FS_NQ / TOL_DIV);
    localparam logic [PW-1:0] FS_HI  = PW'(FS_NQ + FS_NQ / TOL_DIV);
    localparam logic [PW-1:0] LS_LO  = PW'(LS_NQ - LS_NQ / TOL_DIV);
    localparam logic [PW-1:0] LS_HI  = PW'(LS_NQ + LS_NQ / TOL_DIV);

    logic          load;
    logic [PW-1:0] per_q;
    logic [PW-1:0] per_lo;
    logic [PW-1:0] per_hi;
    adj_e          adj;
    logic          sample_hit;
    logic          edge_hit;

    assign load = start && !idle;

    abt_period #(
        .PW(PW), .NOM_FS(NOM_FS), .NOM_LS(NOM_LS),
        .FS_LO(FS_LO), .FS_HI(FS_HI), .LS_LO(LS_LO), .LS_HI(LS_HI)
    ) u_period (
        .clk(clk), .rst(rst), .load(load), .speed_ls(speed_ls),
        .apply(sample_hit), .adj(adj),
        .per(per_q), .per_lo(per_lo), .per_hi(per_hi)
    );

    abt_phase #(
        .INT_W(INT_W), .FRAC_W(FRAC_W), .PW(PW),
        .NOM_FS(NOM_FS), .NOM_LS(NOM_LS)
    ) u_phase (
        .clk(clk), .rst(rst), .load(load), .speed_ls(speed_ls),
        .halt(idle), .per(per_q), .adj(adj),
        .sample_hit(sample_hit), .edge_hit(edge_hit)
    );

    abt_judge u_judge (
        .clk(clk), .rst(rst), .edge_hit(edge_hit),
        .line_sym(line_sym), .sym_changed(sym_changed), .adj(adj)
    );

    assign sample_stb = sample_hit;
    assign edge_stb   = edge_hit;

endmodule

// File: rtl/abt_chk.sv
module abt_chk #(
    parameter int PW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          idle,
    input logic          sym_changed,
    input logic          sample_stb,
    input logic          edge_stb,
    input logic [PW-1:0] per,
    input logic [PW-1:0] per_lo,
    input logic [PW-1:0] per_hi
);

    // R1
    quiet_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!sample_stb && !edge_stb));

    // R10
    idle_silence_chk: assert property (@(posedge clk) disable iff (rst)
        idle |-> (!sample_stb && !edge_stb));

    // R3
    strobe_disjoint_chk: assert property (@(posedge clk) disable iff (rst)
        !(sample_stb && edge_stb));

    // R3
    edge_leads_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !idle) |=> ((edge_stb || idle) && !sample_stb));

    // R7
    hold_period_chk: assert property (@(posedge clk) disable iff (rst)
        (sample_stb && !sym_changed && !start) |=> (per == $past(per)));

    // R8
    period_band_chk: assert property (@(posedge clk) disable iff (rst)
        (per >= per_lo) && (per <= per_hi));

endmodule

bind adaptive_bit_timer abt_chk #(.PW(PW)) u_chk (
    .clk(clk), .rst(rst), .start(start), .idle(idle),
    .sym_changed(sym_changed), .sample_stb(sample_stb), .edge_stb(edge_stb),
    .per(per_q), .per_lo(per_lo), .per_hi(per_hi)
);

// File: tb/tb_adaptive_bit_timer.sv
module tb_adaptive_bit_timer;

    localparam longint CLK_HZ = 64'd48_000_000;
    // nominal periods and clamp bands at 48 MHz (R2, R8)
    localparam longint NFS = 262144;
    localparam longint NLS = 2097152;
    localparam longint FLO = 256902, FHI = 267386;
    localparam longint LLO = 2055209, LHI = 2139095;
    localparam longint M32 = 64'hFFFF_FFFF;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0, speed_ls = 1'b0;
    logic idle = 1'b0, sym_changed = 1'b0;
    logic [1:0] line_sym = 2'b01;
    logic sample_stb, edge_stb;

    always #4 clk = ~clk;

    adaptive_bit_timer #(.CLK_HZ(CLK_HZ), .INT_W(16), .FRAC_W(16), .TOL_DIV(50)) dut (
        .clk(clk), .rst(rst), .start(start), .speed_ls(speed_ls), .idle(idle),
        .line_sym(line_sym), .sym_changed(sym_changed),
        .sample_stb(sample_stb), .edge_stb(edge_stb)
    );

    int total = 0, bad = 0;
    int cyc = 0;

    // reference model state
    longint mper = NFS, mtgt = 0;
    int     mcnt = 0;
    bit     mrun = 0, mls = 0;
    bit     m_s, m_e;
    int     mode_v = 0, bidx = 0, adj_v = 0;
    logic [1:0] cur = 2'b01;
    string  req_s = "R3";

    // mode: 0 steady, 1 early, 2 late, 3 non-data symbols, 6 alternate early/late
    // fields: ls[15] mode[14:12] req[11:8] nbits[7:0]
    localparam int NSC = 8;
    localparam logic [15:0] SCN [NSC] = '{
        {1'b0, 3'd0, 4'd4, 8'd20},   // R4 full speed steady
        {1'b1, 3'd0, 4'd2, 8'd12},   // R2 low speed steady
        {1'b0, 3'd1, 4'd5, 8'd10},   // R5 early edges
        {1'b1, 3'd2, 4'd6, 8'd10},   // R6 late edges
        {1'b0, 3'd3, 4'd7, 8'd16},   // R7 SE0 at edge or sample
        {1'b0, 3'd1, 4'd8, 8'd70},   // R8 lower clamp
        {1'b1, 3'd2, 4'd8, 8'd70},   // R8 upper clamp
        {1'b0, 3'd6, 4'd5, 8'd20}    // R5 R6 alternating
    };

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc >= 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    // choose edge symbol, sample symbol, change flag and expected adjustment
    task automatic pick(output logic [1:0] e_sym, output logic [1:0] n_sym,
                        output bit chg, output int adj);
        int m;
        m = (mode_v == 6) ? ((bidx % 2 == 0) ? 1 : 2) : mode_v;
        case (m)
            1: begin n_sym = ~cur; e_sym = ~cur; chg = 1; adj = 1; end
            2: begin n_sym = ~cur; e_sym = cur;  chg = 1; adj = 2; end
            3: begin
                if (bidx % 2 == 0) begin e_sym = 2'b00; n_sym = ~cur; end
                else begin e_sym = ~cur; n_sym = 2'b00; end
                chg = 1; adj = 0;
            end
            default: begin n_sym = cur; e_sym = cur; chg = 0; adj = 0; end
        endcase
    endtask

    task automatic tick(input bit st, input bit idl);
        logic [1:0] es, ns;
        bit ch;
        int ad;
        longint slip, trim;
        @(negedge clk);
        start = st;
        idle = idl;
        m_s = mrun && !idl && (longint'(mcnt) == ((mtgt >> 16) & 64'hFFFF));
        m_e = mrun && !idl && (longint'(mcnt) == ((((mtgt - (mper >> 1)) & M32) >> 16) & 64'hFFFF));
        pick(es, ns, ch, ad);
        sym_changed = 1'b0;
        if (m_e) line_sym = es;
        if (m_s) begin
            line_sym = ns;
            sym_changed = ch;
            adj_v = ad;
        end
        #1;
        if (idl) check(!sample_stb && !edge_stb, "R10", {sample_stb, edge_stb}, 0);
        else if (m_s || m_e || sample_stb || edge_stb)
            check(sample_stb == m_s && edge_stb == m_e, req_s,
                  {sample_stb, edge_stb}, {m_s, m_e});
        // model update for the coming edge
        if (st && !idl) begin
            mls = speed_ls;
            mper = speed_ls ? NLS : NFS;
            mtgt = (mper >> 1) + 32768;
            mcnt = 0;
            mrun = 1;
        end else begin
            if (mrun) mcnt = (mcnt + 1) & 16'hFFFF;
            if (m_s) begin
                slip = (mper >> 7) + (mper >> 9);
                trim = mper >> 10;
                if (adj_v == 1) begin
                    mtgt = (mtgt + mper - slip) & M32;
                    mper = mper - trim;
                    if (mper < (mls ? LLO : FLO)) mper = mls ? LLO : FLO;
                end else if (adj_v == 2) begin
                    mtgt = (mtgt + mper + slip) & M32;
                    mper = mper + trim;
                    if (mper > (mls ? LHI : FHI)) mper = mls ? LHI : FHI;
                end else begin
                    mtgt = (mtgt + mper) & M32;
                end
                if (ns == 2'b00) cur = 2'b01; else cur = ns;
                bidx++;
            end
            if (idl) mrun = 0;
        end
    endtask

    task automatic run_scn(input bit ls, input int mode, input int nbits, input string req);
        speed_ls = ls;
        mode_v = mode;
        bidx = 0;
        cur = 2'b01;
        req_s = req;
        tick(1, 0);
        while (bidx < nbits) tick(0, 0);
        tick(0, 1);
        req_s = "R10";
        repeat (40) tick(0, 0);
    endtask

    int lat, elat;
    bit seen;

    initial begin
        // R1: quiet in and after reset
        repeat (4) begin
            @(negedge clk);
            #1 check(!sample_stb && !edge_stb, "R1", {sample_stb, edge_stb}, 0);
        end
        @(negedge clk) rst = 1'b0;
        repeat (20) begin
            @(negedge clk);
            #1 check(!sample_stb && !edge_stb, "R1", {sample_stb, edge_stb}, 0);
        end

        // R2 R3: first strobe latency from start, counted in cycles after the start cycle
        for (int s = 0; s < 2; s++) begin
            speed_ls = s[0];
            mode_v = 0; bidx = 0; cur = 2'b01; req_s = "R3";
            tick(1, 0);
            lat = 0; elat = 0;
            while (bidx < 1) begin
                tick(0, 0);
                lat++;
                if (edge_stb && elat == 0) elat = lat;
            end
            check(lat == (s == 1 ? 17 : 3), "R2", lat, s == 1 ? 17 : 3);
            check(elat == 1, "R3", elat, 1);
            tick(0, 1);
            repeat (4) tick(0, 0);
        end

        // table of scenarios walked by one loop
        for (int i = 0; i < NSC; i++)
            run_scn(SCN[i][15], int'(SCN[i][14:12]), int'(SCN[i][7:0]),
                    $sformatf("R%0d", SCN[i][11:8]));

        // R9: restart mid-run with a change of speed
        speed_ls = 1'b0; mode_v = 2; bidx = 0; cur = 2'b01; req_s = "R9";
        tick(1, 0);
        while (bidx < 5) tick(0, 0);
        tick(0, 0);
        speed_ls = 1'b1; mode_v = 0; bidx = 0;
        tick(1, 0);
        while (bidx < 4) tick(0, 0);
        tick(0, 1);
        repeat (4) tick(0, 0);

        // R10: start together with idle is ignored
        req_s = "R10";
        speed_ls = 1'b0;
        tick(1, 1);
        seen = 0;
        repeat (40) begin
            tick(0, 0);
            if (sample_stb || edge_stb) seen = 1;
        end
        check(!seen, "R10", seen, 0);

        finish_run();
    end

endmodule